// File: doc/BRIEF.md
# Horizontal Readout Timing Generator

This block produces the horizontal timing of the read side of a line-doubling frame-buffer controller. It runs entirely in the read clock domain, which is unrelated to the write clock, so it never samples anything from the write side. A free-running position counter steps through one output line whose length is set by an 11-bit line-size value. Five strobes and windows are decoded from that position: a one-clock line reference, a horizontal sync pulse of fixed width, a read-enable window for the line memory, a horizontal-clear strobe that primes the line memory just before the reads begin, and a horizontal blanking pulse.

Each programmed timing point includes a fixed two-clock latency. The blanking pulse only marks the blanked area for the display. It has no effect on the read window, so reads go on through blanking. The line size, phase and blanking values come from registers held elsewhere. The block copies them into shadow registers only at a line boundary, so a register write made partway through a line never shortens or distorts that line.

Top module: `hread_timing_gen`

## Requirements
- R1: The line period is L + 2 read clocks, where L = {cfg_line_hi, cfg_line_lo} is the 11-bit line size (the high part holds bits 10..8 and the low byte holds bits 7..0).
- R2: line_ref is high for exactly one clock at position 0 of every line. Position n is the n-th clock after line_ref, counting line_ref itself as position 0.
- R3: hsync is high at positions 0 to 67, which is 68 clocks, and low for the rest of the line. On a line shorter than 68 clocks it stays high for the whole line.
- R4: rd_en is high from position P + 2 to the last position of the line (position L + 1), where P is cfg_phase. It is low on every position when P + 2 > L + 1.
- R5: hblank is high at positions from B + 2 up to but not including position E, where B is cfg_lblank and E is cfg_rblank. It is never high when E <= B + 2.
- R6: hblank does not gate rd_en. At any position where both windows apply, rd_en is high.
- R7: hclr is a one-clock pulse at position P + 1, one clock before rd_en opens. It does not occur when P + 1 > L + 1.
- R8: The values on the configuration inputs are captured once per line, at the clock edge that begins position 0 of the next line. A change made partway through a line leaves the rest of that line unchanged.
- R9: While rst_n is low at a clock edge (synchronous, active low), all five outputs are low. The first clock after rst_n is released is position 0 of a line that uses the configuration present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_line_lo | input | 8 | Line size, bits 7..0 |
| cfg_line_hi | input | 3 | Line size, bits 10..8 |
| cfg_phase | input | 11 | Read-window phase P |
| cfg_lblank | input | 11 | Blanking start value B |
| cfg_rblank | input | 11 | Blanking end value E |
| line_ref | output | 1 | One-clock line reference at position 0 |
| hsync | output | 1 | Horizontal sync, 68 clocks wide |
| rd_en | output | 1 | Line memory read-enable window |
| hblank | output | 1 | Horizontal blanking (display only) |
| hclr | output | 1 | Line memory horizontal-clear strobe |

## Verification
The bench targets several corner cases. The shortest line (L = 0, period 2) catches a counter that wraps one position late. A line shorter than the sync width catches a sync that wrongly drops when the line restarts. The longest line (L = 2047) needs a 12-bit position, so a counter that is one bit too narrow would wrap early. Phase values that put hclr on the last position with no read window, or push both past the end of the line, catch decoders that wrap around or mis-order hclr and rd_en. A blanking end value at or below the start value catches a pulse that goes high when it should stay low. A blanking window that overlaps the read window catches any gating of rd_en by hblank. A line-size change in the middle of a line must leave the old period in place until the next line_ref; a design without shadowing would shorten or stretch that line. A reset asserted in the middle of a line must clear the outputs at once and restart at position 0.

// File: rtl/hrt_pkg.sv
// Package: shared width and configuration type of the horizontal readout
// timing generator. Assumes the line size and all timing points share one width.
package hrt_pkg;
    parameter int unsigned HRT_LINE_W = 11;

    // One snapshot of the timing registers, as held in the line shadow.
    typedef struct packed {
        logic [HRT_LINE_W-1:0] line;
        logic [HRT_LINE_W-1:0] phase;
        logic [HRT_LINE_W-1:0] lblank;
        logic [HRT_LINE_W-1:0] rblank;
    } hrt_cfg_t;
endpackage

// File: rtl/hrt_cfg_shadow.sv
// Module: line-boundary shadow of the timing configuration.
// Captures cfg_in whenever load is high or reset is active. Otherwise it holds
// its value, so downstream decoders see constant settings for a whole line.
module hrt_cfg_shadow
    import hrt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  hrt_cfg_t cfg_in,
    output hrt_cfg_t cfg_q
);
    // Shadow capture: follow the inputs in reset and at each line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/hrt_line_counter.sv
// Module: position counter for one read line.
// Counts 0..last_pos and then wraps. The run flag stays low through reset and
// for the first edge after it, so the first active clock is position 0.
// Assumes last_pos fits in CW bits.
module hrt_line_counter #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] last_pos,
    output logic [CW-1:0] pos,
    output logic          run,
    output logic          wrap
);
    // End of line: the counter is active and sits on the last position.
    always_comb begin
        wrap = run && (pos == last_pos);
    end

    // Counter and run flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
            run <= 1'b0;
        end else begin
            run <= 1'b1;
            if (run) begin
                pos <= wrap ? '0 : pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hrt_span.sv
// Module: half-open position window decoder.
// active is high while en is set and lo <= pos < hi. It is never high when
// hi <= lo. Purely combinational; the caller supplies registered inputs.
module hrt_span #(
    parameter int unsigned CW = 12
) (
    input  logic          en,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output logic          active
);
    // Window membership test.
    always_comb begin
        active = en && (pos >= lo) && (pos < hi);
    end
endmodule

// File: rtl/hread_timing_gen.sv
// Module: horizontal readout timing generator (top).
// Decodes line_ref, hsync, rd_en, hblank and hclr from one line position
// counter. All timing points carry the fixed LAT latency. Configuration is
// shadowed at each line boundary. Assumes a single read clock domain and a
// synchronous active-low reset. Outputs decode registered state only.
module hread_timing_gen
    import hrt_pkg::*;
#(
    parameter int unsigned SYNC_LEN = 68,
    parameter int unsigned LAT      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            cfg_line_lo,
    input  logic [HRT_LINE_W-9:0] cfg_line_hi,
    input  logic [HRT_LINE_W-1:0] cfg_phase,
    input  logic [HRT_LINE_W-1:0] cfg_lblank,
    input  logic [HRT_LINE_W-1:0] cfg_rblank,
    output logic                  line_ref,
    output logic                  hsync,
    output logic                  rd_en,
    output logic                  hblank,
    output logic                  hclr
);
    localparam int unsigned CW    = HRT_LINE_W + 1;
    localparam int unsigned NSPAN = 3;
    localparam logic [CW-1:0] LAT_V  = CW'(LAT);
    localparam logic [CW-1:0] LAT_M1 = CW'(LAT - 1);
    localparam logic [CW-1:0] SYNC_V = CW'(SYNC_LEN);

    hrt_cfg_t      cfg_in;
    hrt_cfg_t      cfg_q;
    logic [CW-1:0] pos;
    logic [CW-1:0] last_pos;
    logic          run;
    logic          wrap;
    logic [CW-1:0] span_lo [NSPAN];
    logic [CW-1:0] span_hi [NSPAN];
    logic [NSPAN-1:0] span_on;

    // Assemble the incoming configuration snapshot.
    always_comb begin
        cfg_in.line   = {cfg_line_hi, cfg_line_lo};
        cfg_in.phase  = cfg_phase;
        cfg_in.lblank = cfg_lblank;
        cfg_in.rblank = cfg_rblank;
    end

    hrt_cfg_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (!run || wrap),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    // Last position of the line: line size plus latency minus one.
    always_comb begin
        last_pos = {1'b0, cfg_q.line} + LAT_M1;
    end

    hrt_line_counter #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_pos (last_pos),
        .pos      (pos),
        .run      (run),
        .wrap     (wrap)
    );

    // Window bounds: sync, read enable, blanking.
    always_comb begin
        span_lo[0] = '0;
        span_hi[0] = SYNC_V;
        span_lo[1] = {1'b0, cfg_q.phase} + LAT_V;
        span_hi[1] = {1'b0, cfg_q.line} + LAT_V;
        span_lo[2] = {1'b0, cfg_q.lblank} + LAT_V;
        span_hi[2] = {1'b0, cfg_q.rblank};
    end

    for (genvar g = 0; g < NSPAN; g++) begin : g_span
        hrt_span #(.CW(CW)) u_span (
            .en     (run),
            .pos    (pos),
            .lo     (span_lo[g]),
            .hi     (span_hi[g]),
            .active (span_on[g])
        );
    end

    // Output decode from the counter and the windows.
    always_comb begin
        line_ref = run && (pos == '0);
        hsync    = span_on[0];
        rd_en    = span_on[1];
        hblank   = span_on[2];
        hclr     = run && (pos == ({1'b0, cfg_q.phase} + LAT_M1));
    end
endmodule

// File: rtl/hrt_checker.sv
// Module: property checker for hread_timing_gen, attached with bind.
// Observes only the top-level ports.
module hrt_checker (
    input logic clk,
    input logic rst_n,
    input logic line_ref,
    input logic hsync,
    input logic rd_en,
    input logic hblank,
    input logic hclr
);
    // R9: a clock edge with reset low leaves every output low.
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> !(line_ref || hsync || rd_en || hblank || hclr));

    // R2: the line reference never lasts two clocks.
    assert_ref_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_ref |=> !line_ref);

    // R3: sync only starts together with the line reference.
    assert_sync_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> line_ref);

    // R4: the read window is closed at line position 0.
    assert_rd_closed_at_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_ref |-> !rd_en);

    // R7: the read window opens only right after a clear strobe.
    assert_clr_before_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> $past(hclr));

    // R7: the clear strobe is one clock wide.
    assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hclr |=> !hclr);
endmodule

bind hread_timing_gen hrt_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_ref (line_ref),
    .hsync    (hsync),
    .rd_en    (rd_en),
    .hblank   (hblank),
    .hclr     (hclr)
);

// File: tb/hread_timing_gen_tb_top.sv
// Bench: behavioural line-position model compared on every clock.
module hread_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_line_lo = 8'd100;
    logic [2:0]  cfg_line_hi = 3'd0;
    logic [10:0] cfg_phase = 11'd10;
    logic [10:0] cfg_lblank = 11'd5;
    logic [10:0] cfg_rblank = 11'd40;
    logic line_ref, hsync, rd_en, hblank, hclr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // model state
    int m_run = 0, m_pos = 0, m_L = 0, m_P = 0, m_B = 0, m_E = 0;
    int prev_ref_cyc = -1, exp_period = 0;
    bit r8_pending = 1'b0;
    int r8_expect = 0;

    hread_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_line_lo(cfg_line_lo), .cfg_line_hi(cfg_line_hi),
        .cfg_phase(cfg_phase), .cfg_lblank(cfg_lblank), .cfg_rblank(cfg_rblank),
        .line_ref(line_ref), .hsync(hsync), .rd_en(rd_en),
        .hblank(hblank), .hclr(hclr)
    );

    always #10 clk = ~clk;

    task automatic grab_cfg();
        m_L = {cfg_line_hi, cfg_line_lo};
        m_P = cfg_phase;
        m_B = cfg_lblank;
        m_E = cfg_rblank;
    endtask

    // model step at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pos = 0; grab_cfg();
        end else if (m_run == 0) begin
            m_run = 1; m_pos = 0; grab_cfg();
        end else if (m_pos == m_L + 1) begin
            m_pos = 0; grab_cfg();
        end else begin
            m_pos = m_pos + 1;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d pos %0d: actual %b expected %b", req, cyc, m_pos, act, exp);
        end
    endtask

    // compare on the falling edge
    always @(negedge clk) begin
        logic e_lr, e_hs, e_rd, e_hb, e_hc;
        cyc++;
        e_lr = (m_run == 1) && (m_pos == 0);
        e_hs = (m_run == 1) && (m_pos < 68);
        e_rd = (m_run == 1) && (m_pos >= m_P + 2);
        e_hb = (m_run == 1) && (m_pos >= m_B + 2) && (m_pos < m_E);
        e_hc = (m_run == 1) && (m_pos == m_P + 1);
        if (m_run == 0) begin
            chk("R9", line_ref | hsync | rd_en | hblank | hclr, 1'b0);
        end
        chk("R2", line_ref, e_lr);
        chk("R3", hsync, e_hs);
        chk("R4", rd_en, e_rd);
        chk("R5", hblank, e_hb);
        chk("R7", hclr, e_hc);
        if (e_rd && e_hb) chk("R6", rd_en, 1'b1);
        if (line_ref === 1'b1) begin
            if (prev_ref_cyc >= 0) begin
                checks++;
                if (cyc - prev_ref_cyc != exp_period) begin
                    errors++;
                    $display("FAIL R1 line period: actual %0d expected %0d", cyc - prev_ref_cyc, exp_period);
                end
                if (r8_pending) begin
                    r8_pending = 1'b0;
                    checks++;
                    if (cyc - prev_ref_cyc != r8_expect) begin
                        errors++;
                        $display("FAIL R8 period after mid-line change: actual %0d expected %0d", cyc - prev_ref_cyc, r8_expect);
                    end
                end
            end
            prev_ref_cyc = cyc;
            exp_period = m_L + 2;
        end
        if (!rst_n) prev_ref_cyc = -1;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected finish", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int l, input int p, input int b, input int e);
        cfg_line_lo = l[7:0];
        cfg_line_hi = l[10:8];
        cfg_phase = p[10:0];
        cfg_lblank = b[10:0];
        cfg_rblank = e[10:0];
    endtask

    initial begin
        cycles(5);
        rst_n = 1'b1;                       // R9 restart
        cycles(320);
        set_cfg(200, 150, 60, 190);         // R6 overlap of blanking and reads
        cycles(700);
        // R8: change line size partway through a line
        @(negedge clk iff line_ref === 1'b1);
        cycles(20);
        r8_expect = {cfg_line_hi, cfg_line_lo} + 2;
        r8_pending = 1'b1;
        set_cfg(30, 3, 0, 2);               // short line, empty blanking
        cycles(200);
        set_cfg(0, 0, 0, 0);                // shortest line
        cycles(30);
        set_cfg(2047, 2000, 2040, 2047);    // longest line
        cycles(4200);
        set_cfg(2047, 2047, 100, 50);       // hclr on last position, no reads
        cycles(4200);
        set_cfg(90, 95, 10, 30);            // phase beyond the line
        cycles(300);
        set_cfg(120, 0, 3, 100);
        cycles(57);
        rst_n = 1'b0;                       // R9 reset partway through a line
        cycles(3);
        rst_n = 1'b1;
        cycles(400);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule